// File: doc/BRIEF.md
# NMI Source Combiner

This block folds four non-maskable interrupt requests into a single NMI line for the processor: an asynchronous active-high external pin, a clock-failure request from an oscillator monitor, a software trigger, and a watchdog time-out. The watchdog request counts only while the watchdog is configured for NMI mode. Every source sets its own sticky bit in a cause register. The NMI output says nothing about which source fired, so software reads the cause register to find out and clears the bits it has handled by writing ones to them.

The external pin source is off after reset. Software can turn it on only through a protection sequence. First it writes a fixed 32-bit key, which opens the lock. Next it arms a commit bit. Then it writes the enable. That enable write uses up the unlock, and the lock closes again. A small word-addressed register port covers the key, commit, software trigger, pin enable and cause functions. Reads from this port are combinational.

Top module: `nmi_combiner`

## Requirements
- R1: `nmi_o` is high exactly when at least one cause bit is set. A read at word address 4 returns the cause bits in [3:0], in this order: bit 0 = pin, bit 1 = oscillator failure, bit 2 = software, bit 3 = watchdog. The upper bits read as 0.
- R2: If `osc_fail_i` is high at a rising clock edge, cause bit 1 is set after that edge.
- R3: Writing address 2 with bit 0 = 1 loads a trigger bit. That bit clears itself after one cycle and sets cause bit 2 on the edge that follows. Address 2 always reads 0.
- R4: If `wdt_timeout_i` and `wdt_nmi_mode_i` are both high at an edge, cause bit 3 is set after that edge. If the mode input is low, a time-out has no effect.
- R5: The pin passes through a two-flop synchronizer. A rising edge of the synchronized level while the pin enable is 1 sets cause bit 0 on the third clock edge after the pin rises. A pin that stays high does not set the bit again. Pin activity while the enable is 0 is ignored.
- R6: Writing the key 32'h4E4D_4921 to address 0 unlocks. Writing any other value to address 0 locks and disarms. Address 0 reads the unlocked flag in bit 0.
- R7: A write to address 1 while unlocked sets the commit-armed flag to bit 0 of the data. The same write while locked is ignored. Address 1 reads the armed flag in bit 0.
- R8: A write to address 3 loads the pin enable from data bit 0, but only while the block is unlocked and armed. That write then clears both the unlocked and armed flags. Otherwise a write to address 3 is ignored. Address 3 reads the enable in bit 0.
- R9: Writing address 4 clears each cause bit whose data bit is 1. Bits written with 0 are kept. A source that sets a bit in the same cycle as a clear of that bit wins.
- R10: After reset, all cause bits are 0, the pin enable is 0, the block is locked and not armed, and `nmi_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External NMI pin, asynchronous, active high |
| osc_fail_i | input | 1 | Oscillator monitor failure request |
| wdt_timeout_i | input | 1 | Watchdog time-out request |
| wdt_nmi_mode_i | input | 1 | Watchdog interrupt type: 1 selects NMI |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| nmi_o | output | 1 | Combined NMI request |

## Verification
The bench attacks the protection sequence at every step: a wrong key, a commit while locked, an enable while locked or unarmed, and a second enable after a successful one. A design that skips any of these gates lets the pin enable change without the full unlock, which shows up in the enable readback. For the pin, the bench samples one cycle before and exactly at the synchronizer latency and holds the pin high after clearing its cause bit. A missing stage, an extra stage, or level-based rather than edge-based detection all move or repeat the cause bit. The bench also gives a watchdog time-out with the mode low, clears a bit in the same cycle that its source sets it, and runs random mixes of sources and clear masks. Wrong gating, clear winning over set, or a clear that spreads to other bits each show up as a mismatch in the cause value.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned NUM_SRC     = 4;
  localparam int unsigned SRC_PIN     = 0;
  localparam int unsigned SRC_OSC     = 1;
  localparam int unsigned SRC_SW      = 2;
  localparam int unsigned SRC_WDT     = 3;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_KEY    = 0;
  localparam int unsigned ADDR_COMMIT = 1;
  localparam int unsigned ADDR_CTRL   = 2;
  localparam int unsigned ADDR_ENABLE = 3;
  localparam int unsigned ADDR_CAUSE  = 4;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_lock_ctrl.sv
module nmi_lock_ctrl #(
  parameter int unsigned          DATA_W = 32,
  parameter logic [DATA_W-1:0]    KEY    = 32'h4E4D_4921
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic              commit_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic              armed_o,
  output logic              pin_en_o
);
  logic unlocked_q, armed_q, pin_en_q;
  logic key_match;

  assign key_match = (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
      pin_en_q   <= 1'b0;
    end else if (en_wr_i && unlocked_q && armed_q) begin
      // committed change consumes the unlock
      pin_en_q   <= wdata_i[0];
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
    end else if (key_wr_i) begin
      unlocked_q <= key_match;
      if (!key_match) armed_q <= 1'b0;
    end else if (commit_wr_i && unlocked_q) begin
      armed_q <= wdata_i[0];
    end
  end

  assign unlocked_o = unlocked_q;
  assign armed_o    = armed_q;
  assign pin_en_o   = pin_en_q;
endmodule

// File: rtl/nmi_cause_reg.sv
module nmi_cause_reg #(
  parameter int unsigned NUM = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] cause_o
);
  logic [NUM-1:0] cause_q;

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cause_q[i] <= 1'b0;
        else if (set_i[i]) cause_q[i] <= 1'b1;  // set wins over clear
        else if (clr_i[i]) cause_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign cause_o = cause_q;
endmodule

// File: rtl/nmi_combiner.sv
module nmi_combiner
  import nmi_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 3,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [31:0]       UNLOCK_KEY  = 32'h4E4D_4921
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              osc_fail_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_nmi_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              nmi_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic wr_key, wr_commit, wr_ctrl, wr_enable, wr_cause;
  logic unlocked, armed, pin_en;
  logic pin_sync, pin_sync_d;
  logic sw_trig_q;
  logic [NUM_SRC-1:0] set_vec, clr_vec, cause_q;

  assign wr_key    = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_KEY));
  assign wr_commit = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_COMMIT));
  assign wr_ctrl   = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_enable = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_ENABLE));
  assign wr_cause  = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CAUSE));

  nmi_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_sync_d <= 1'b0;
      sw_trig_q  <= 1'b0;
    end else begin
      pin_sync_d <= pin_sync;
      sw_trig_q  <= wr_ctrl && reg_wdata_i[0];  // self-clearing trigger
    end
  end

  nmi_lock_ctrl #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (wr_key),
    .commit_wr_i(wr_commit),
    .en_wr_i    (wr_enable),
    .wdata_i    (reg_wdata_i),
    .unlocked_o (unlocked),
    .armed_o    (armed),
    .pin_en_o   (pin_en)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_PIN] = pin_en && pin_sync && !pin_sync_d;
    set_vec[SRC_OSC] = osc_fail_i;
    set_vec[SRC_SW]  = sw_trig_q;
    set_vec[SRC_WDT] = wdt_timeout_i && wdt_nmi_mode_i;
  end

  assign clr_vec = wr_cause ? reg_wdata_i[NUM_SRC-1:0] : '0;

  nmi_cause_reg #(.NUM(NUM_SRC)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .cause_o(cause_q)
  );

  assign nmi_o = |cause_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(ADDR_KEY):    reg_rdata_o[0] = unlocked;
      ADDR_W'(ADDR_COMMIT): reg_rdata_o[0] = armed;
      ADDR_W'(ADDR_ENABLE): reg_rdata_o[0] = pin_en;
      ADDR_W'(ADDR_CAUSE):  reg_rdata_o    = {{PAD_W{1'b0}}, cause_q};
      default:              reg_rdata_o    = '0;
    endcase
  end
endmodule

// File: rtl/nmi_combiner_chk.sv
module nmi_combiner_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter logic [31:0] KEY    = 32'h4E4D_4921
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              osc_fail_i,
  input logic              wdt_timeout_i,
  input logic              wdt_nmi_mode_i,
  input logic [3:0]        cause,
  input logic              pin_en,
  input logic              unlocked
);
  logic [3:0] clr_mask, keep;
  assign clr_mask = (reg_we_i && reg_addr_i == ADDR_W'(4)) ? reg_wdata_i[3:0] : 4'b0;
  assign keep     = cause & ~clr_mask;

  a_r2_osc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fail_i |=> cause[1]);

  a_r3_sw_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(2) && reg_wdata_i[0]) |-> ##2 cause[2]);

  a_r4_wdt_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause[3]) |-> $past(wdt_timeout_i && wdt_nmi_mode_i));

  a_r5_pin_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause[0]) |-> $past(pin_en));

  a_r6_bad_key_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(0) && reg_wdata_i != KEY) |=> !unlocked);

  a_r8_enable_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(3) && !unlocked) |=> $stable(pin_en));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause & $past(keep)) == $past(keep)));
endmodule

bind nmi_combiner nmi_combiner_chk #(.ADDR_W(ADDR_W), .KEY(UNLOCK_KEY)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .osc_fail_i    (osc_fail_i),
  .wdt_timeout_i (wdt_timeout_i),
  .wdt_nmi_mode_i(wdt_nmi_mode_i),
  .cause         (cause_q),
  .pin_en        (pin_en),
  .unlocked      (unlocked)
);

// File: tb/nmi_combiner_tb.sv
module nmi_combiner_tb;
  localparam logic [31:0] KEY = 32'h4E4D_4921;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 0, osc = 0, wdt = 0, wmode = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nmi;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nmi_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .osc_fail_i(osc),
    .wdt_timeout_i(wdt), .wdt_nmi_mode_i(wmode), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .nmi_o(nmi)
  );

  function automatic logic [3:0] next_cause(logic [3:0] c, logic [3:0] s, logic [3:0] clr);
    return s | (c & ~clr);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_osc();
    @(negedge clk); osc = 1;
    @(negedge clk); osc = 0;
  endtask

  task automatic pulse_wdt(logic m);
    @(negedge clk); wdt = 1; wmode = m;
    @(negedge clk); wdt = 0; wmode = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  exp_c;
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    rd(4, d); chk("R10 cause", d, 0);
    rd(3, d); chk("R10 enable", d, 0);
    rd(0, d); chk("R10 unlocked", d, 0);
    rd(1, d); chk("R10 armed", d, 0);
    chk("R10 nmi", {31'b0, nmi}, 0);

    // R5 pin ignored while disabled
    @(negedge clk); pin = 1;
    repeat (5) @(negedge clk);
    rd(4, d); chk("R5 pin disabled", d, 0);
    pin = 0; repeat (3) @(negedge clk);

    // R6/R7/R8 protection
    wr(0, KEY ^ 32'h1); rd(0, d); chk("R6 wrong key", d, 0);
    wr(1, 1);           rd(1, d); chk("R7 commit locked", d, 0);
    wr(3, 1);           rd(3, d); chk("R8 enable locked", d, 0);
    wr(0, KEY);         rd(0, d); chk("R6 key unlocks", d, 1);
    wr(3, 1);           rd(3, d); chk("R8 enable unarmed", d, 0);
    wr(1, 1);           rd(1, d); chk("R7 commit armed", d, 1);
    wr(3, 1);           rd(3, d); chk("R8 enable set", d, 1);
    rd(0, d); chk("R8 relocked", d, 0);
    rd(1, d); chk("R8 disarmed", d, 0);
    wr(3, 0);           rd(3, d); chk("R8 second write ignored", d, 1);

    // R5 pin latency: rises before edge k, cause after k+2
    @(negedge clk); pin = 1;
    @(negedge clk); @(negedge clk);
    rd(4, d); chk("R5 not yet", d, 0);
    @(negedge clk);
    rd(4, d); chk("R5 pin cause", d, 32'h1);
    chk("R1 nmi high", {31'b0, nmi}, 1);

    // R9 clear semantics
    wr(4, 32'hE);  rd(4, d); chk("R9 zero bits kept", d, 32'h1);
    wr(4, 32'h1);  rd(4, d); chk("R9 w1c", d, 0);
    chk("R1 nmi low", {31'b0, nmi}, 0);
    repeat (4) @(negedge clk);
    rd(4, d); chk("R5 level no retrigger", d, 0);
    pin = 0;

    // R4 gating
    pulse_wdt(0); rd(4, d); chk("R4 mode off", d, 0);
    pulse_wdt(1); rd(4, d); chk("R4 mode on", d, 32'h8);
    wr(4, 32'hF);

    // R3 software trigger
    wr(2, 1); rd(2, d); chk("R3 ctrl reads zero", d, 0);
    @(negedge clk); rd(4, d); chk("R3 sw cause", d, 32'h4);
    wr(4, 32'hF);

    // R9 set wins over clear, R2 osc
    @(negedge clk); osc = 1; we = 1; addr = 4; wdata = 32'h2;
    @(negedge clk); osc = 0; we = 0; wdata = 0;
    rd(4, d); chk("R9 set wins", d, 32'h2);
    wr(4, 32'hF);

    // random mix
    exp_c = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: begin pulse_osc(); exp_c = next_cause(exp_c, 4'h2, 4'h0); end
        1: begin
             logic m;
             m = 1'($urandom_range(0, 1));
             pulse_wdt(m);
             exp_c = next_cause(exp_c, m ? 4'h8 : 4'h0, 4'h0);
           end
        2: begin wr(2, 1); @(negedge clk); exp_c = next_cause(exp_c, 4'h4, 4'h0); end
        default: begin
             logic [3:0] msk;
             msk = 4'($urandom_range(0, 15));
             wr(4, {28'b0, msk});
             exp_c = next_cause(exp_c, 4'h0, msk);
           end
      endcase
      rd(4, d);
      chk(op == 0 ? "R2 random" : op == 1 ? "R4 random" : op == 2 ? "R3 random" : "R9 random",
          d, {28'b0, exp_c});
      chk("R1 random nmi", {31'b0, nmi}, {31'b0, |exp_c});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule